// File: doc/BRIEF.md
# Triggered TDC Hit Buffer with Zero-Suppressed Readout

This block is the digital back end of a four-channel time-to-digital converter. An external interpolator supplies, on every core clock, a hit flag and a fine-time value for each channel and each edge polarity. Rising edges carry a 5-bit fine time and falling edges a 4-bit fine time, because the falling edge is measured at half the resolution. The block writes one entry per clock into a 256-entry circular latency buffer. The index of an entry serves as its coarse time stamp.

A level-1 trigger does not start readout directly. The block first computes the start of the trigger's window, which is the current write index minus a programmable latency, and places it in a short pending-trigger queue. An event builder takes triggers from that queue one at a time. For each one it writes a header word and then the window's data words into a 128-word readout FIFO. In fixed-size mode every slot of the window is emitted. In zero-suppressed mode only slots that hold a hit are emitted. When the FIFO is full the builder waits, so no word is ever lost.

Top module: `tdc_hit_buffer`

## Requirements
- R1: After a synchronous reset, `rd_valid`, `fifo_full` and `trig_ovf` are all 0.
- R2: The first rising clock edge with `rst_n` high writes latency-buffer address 0, and each later edge writes the next address modulo 256. A trigger sampled on the edge that writes address W selects a window that starts at (W - `latency`) mod 256 and covers 2 consecutive addresses.
- R3: The pending-trigger queue holds 4 triggers. A trigger that arrives while the queue is full is dropped and sets `trig_ovf`, which stays 1 until reset.
- R4: Each event begins with a header word: bit 17 = 1, bits 16..4 = 0, bits 3..0 = the number of events started before it since reset, modulo 16.
- R5: A data word is: bit 17 = 0, bit 16 = hit flag, bits 15..14 = channel, bit 13 = edge (0 rising, 1 falling), bits 12..5 = latency-buffer address of the slot, bits 4..0 = fine time.
- R6: In fixed-size mode (`zs_mode` = 0) an event is a header followed by 16 data words, ordered by window offset, then channel, then rising before falling. A slot without a hit has hit flag 0 and fine time 0.
- R7: In zero-suppressed mode (`zs_mode` = 1) an event is a header followed only by the slots that hold a hit, in the same order. A hit whose fine time is 0 is still emitted. The mode is sampled when the event starts.
- R8: A falling-edge fine time is 4 bits wide and appears zero-extended in bits 4..0 of its data word.
- R9: The readout FIFO holds 128 words. `fifo_full` is 1 while it holds 128 words, and the builder then stalls without losing or repeating any word. `rd_data` shows the oldest word while `rd_valid` is 1, and `rd_en` removes it on the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rise_hit | input | 4 | Rising-edge hit flag, one bit per channel |
| rise_fine | input | 20 | Rising fine times, 5 bits per channel, channel 0 in the low bits |
| fall_hit | input | 4 | Falling-edge hit flag, one bit per channel |
| fall_fine | input | 16 | Falling fine times, 4 bits per channel, channel 0 in the low bits |
| latency | input | 8 | Trigger latency in clocks |
| zs_mode | input | 1 | 1 selects zero-suppressed readout |
| trig | input | 1 | Level-1 trigger, one clock per trigger |
| rd_en | input | 1 | Pop the word shown on rd_data |
| rd_data | output | 18 | Oldest word in the readout FIFO |
| rd_valid | output | 1 | Readout FIFO not empty |
| fifo_full | output | 1 | Readout FIFO holds 128 words |
| trig_ovf | output | 1 | Sticky flag: a trigger was dropped |

## Verification
A table of single-hit patterns varies the channel, edge polarity, window offset, fine value (including a zero fine on a real hit) and latency, in both readout modes. The position and coarse field of the returned word show whether the window arithmetic and slot ordering are right, and the word count separates fixed-size from zero-suppressed behaviour. A burst of back-to-back triggers with no hits shows exactly how many triggers the queue accepts before it drops one. Nine triggers without any reads drive the FIFO to full, and the word and header totals read back afterwards show whether the stall lost or duplicated data.

// File: rtl/tdc_hitbuf_pkg.sv
// Package: shared types and format constants for the TDC hit buffer.
// Assumes the event word layout fixed by the top module's derived widths.
package tdc_hitbuf_pkg;
    // Event builder states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_SCAN = 2'd2
    } bld_state_t;

    // Width of the event counter carried in header words
    localparam int CNT_W = 4;
endpackage

// File: rtl/tdc_sync_fifo.sv
// Module: synchronous show-ahead FIFO, used both as the pending-trigger
// queue and as the readout FIFO.
// Assumes DEPTH is a power of two and that the user never pushes when full
// nor pops when empty.
module tdc_sync_fifo #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;

    // Storage write, no reset needed
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            case ({push, pop})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // Flags and head-of-queue data
    always_comb begin
        dout  = mem[rp];
        empty = (cnt == '0);
        full  = (cnt == (AW+1)'(DEPTH));
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);  // R9
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);  // R9
endmodule

// File: rtl/tdc_l1_ring.sv
// Module: circular latency buffer. Writes one entry of all channels every
// clock at an incrementing pointer and offers an asynchronous read port.
// Assumes the reader stays at least one window behind the write pointer.
module tdc_l1_ring #(
    parameter int NCH    = 4,
    parameter int RISE_W = 5,
    parameter int FALL_W = 4,
    parameter int DEPTH  = 256
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NCH-1:0]                rise_hit,
    input  logic [NCH*RISE_W-1:0]         rise_fine,
    input  logic [NCH-1:0]                fall_hit,
    input  logic [NCH*FALL_W-1:0]         fall_fine,
    input  logic [$clog2(DEPTH)-1:0]      rd_addr,
    output logic [NCH*(2+RISE_W+FALL_W)-1:0] rd_entry,
    output logic [$clog2(DEPTH)-1:0]      wptr
);
    localparam int AW    = $clog2(DEPTH);
    localparam int ENT_W = 2 + RISE_W + FALL_W;

    logic [NCH*ENT_W-1:0] mem [DEPTH];
    logic [NCH*ENT_W-1:0] wr_entry;

    // Pack each channel as {rise valid, rise fine, fall valid, fall fine};
    // fine fields are cleared when their edge has no hit
    for (genvar c = 0; c < NCH; c++) begin : g_pack
        assign wr_entry[c*ENT_W +: ENT_W] = {
            rise_hit[c], rise_hit[c] ? rise_fine[c*RISE_W +: RISE_W] : RISE_W'(0),
            fall_hit[c], fall_hit[c] ? fall_fine[c*FALL_W +: FALL_W] : FALL_W'(0)};
    end

    // Write the current sample every clock
    always_ff @(posedge clk) begin
        mem[wptr] <= wr_entry;
    end

    // Advance the write pointer every clock after reset
    always_ff @(posedge clk) begin
        if (!rst_n) wptr <= '0;
        else        wptr <= wptr + AW'(1);
    end

    // Read port for the event builder
    always_comb rd_entry = mem[rd_addr];

    AST_WPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> wptr == $past(wptr) + AW'(1));  // R2
endmodule

// File: rtl/tdc_event_builder.sv
// Module: event builder. Takes one pending trigger at a time, emits a header
// and then walks every (offset, channel, edge) slot of the window, emitting
// all slots or only hit slots according to the mode latched at event start.
// Stalls on a full readout FIFO. Assumes WIN and NCH are powers of two, WIN >= 2.
module tdc_event_builder
    import tdc_hitbuf_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int RISE_W = 5,
    parameter int FALL_W = 4,
    parameter int AW     = 8,
    parameter int WIN    = 2,
    parameter int WORD_W = 18
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          q_empty,
    input  logic [AW-1:0]                 q_addr,
    output logic                          q_pop,
    input  logic                          zs_mode,
    output logic [AW-1:0]                 l1_addr,
    input  logic [NCH*(2+RISE_W+FALL_W)-1:0] l1_entry,
    input  logic                          fifo_full,
    output logic                          push,
    output logic [WORD_W-1:0]             word
);
    localparam int ENT_W  = 2 + RISE_W + FALL_W;
    localparam int CH_W   = $clog2(NCH);
    localparam int WOFF_W = $clog2(WIN);
    localparam int SLOTS  = WIN * NCH * 2;
    localparam int IDX_W  = $clog2(SLOTS);

    bld_state_t        state;
    logic [AW-1:0]     base;
    logic              zs_lat;
    logic [IDX_W-1:0]  idx;
    logic [CNT_W-1:0]  ev_cnt;

    logic              slot_edge;
    logic [CH_W-1:0]   slot_ch;
    logic [WOFF_W-1:0] slot_woff;
    logic [ENT_W-1:0]  ent;
    logic              slot_hit;
    logic [RISE_W-1:0] slot_fine;
    logic              want;
    logic              advance;

    // Decode the slot index and select the channel's entry fields
    always_comb begin
        slot_edge = idx[0];
        slot_ch   = idx[CH_W:1];
        slot_woff = idx[IDX_W-1 -: WOFF_W];
        l1_addr   = base + AW'(slot_woff);
        ent       = l1_entry[int'(slot_ch)*ENT_W +: ENT_W];
        slot_hit  = slot_edge ? ent[FALL_W] : ent[ENT_W-1];
        slot_fine = slot_edge ? RISE_W'(ent[FALL_W-1:0]) : ent[ENT_W-2 -: RISE_W];
    end

    // Output word, push and queue-pop decisions per state
    always_comb begin
        q_pop   = 1'b0;
        push    = 1'b0;
        advance = 1'b0;
        want    = 1'b0;
        word    = {1'b0, slot_hit, slot_ch, slot_edge, l1_addr, slot_fine};
        case (state)
            ST_IDLE: q_pop = !q_empty;
            ST_HDR: begin
                push = !fifo_full;
                word = {1'b1, {(WORD_W-1-CNT_W){1'b0}}, ev_cnt};
            end
            ST_SCAN: begin
                want    = zs_lat ? slot_hit : 1'b1;
                push    = want && !fifo_full;
                advance = !want || !fifo_full;
            end
            default: ;
        endcase
    end

    // Sequence one event: take trigger, write header, walk all slots
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            base   <= '0;
            zs_lat <= 1'b0;
            idx    <= '0;
            ev_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: if (!q_empty) begin
                    base   <= q_addr;
                    zs_lat <= zs_mode;
                    state  <= ST_HDR;
                end
                ST_HDR: if (!fifo_full) begin
                    ev_cnt <= ev_cnt + CNT_W'(1);
                    idx    <= '0;
                    state  <= ST_SCAN;
                end
                ST_SCAN: if (advance) begin
                    if (idx == IDX_W'(SLOTS-1)) state <= ST_IDLE;
                    else                        idx   <= idx + IDX_W'(1);
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_ZS_ONLY_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && zs_lat && push) |-> word[WORD_W-2]);  // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SCAN && !zs_lat && fifo_full) |=> $stable(idx));  // R9
    AST_HDR_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !q_empty) |=> state == ST_HDR);  // R4
endmodule

// File: rtl/tdc_hit_buffer.sv
// Module: top of the triggered TDC hit buffer. Connects the latency ring,
// the pending-trigger queue, the event builder and the readout FIFO, and
// keeps the sticky trigger-overflow flag.
// Assumes latency >= WIN and that events are read out well within one
// ring turn of their trigger.
module tdc_hit_buffer #(
    parameter int NCH        = 4,
    parameter int RISE_W     = 5,
    parameter int FALL_W     = 4,
    parameter int L1_DEPTH   = 256,
    parameter int WIN        = 2,
    parameter int TRIGQ_DEPTH = 4,
    parameter int FIFO_DEPTH = 128,
    localparam int AW        = $clog2(L1_DEPTH),
    localparam int WORD_W    = 2 + $clog2(NCH) + 1 + AW + RISE_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NCH-1:0]        rise_hit,
    input  logic [NCH*RISE_W-1:0] rise_fine,
    input  logic [NCH-1:0]        fall_hit,
    input  logic [NCH*FALL_W-1:0] fall_fine,
    input  logic [AW-1:0]         latency,
    input  logic                  zs_mode,
    input  logic                  trig,
    input  logic                  rd_en,
    output logic [WORD_W-1:0]     rd_data,
    output logic                  rd_valid,
    output logic                  fifo_full,
    output logic                  trig_ovf
);
    localparam int ENT_W = 2 + RISE_W + FALL_W;

    logic [AW-1:0]        wptr;
    logic [AW-1:0]        l1_addr;
    logic [NCH*ENT_W-1:0] l1_entry;
    logic                 q_push, q_pop, q_empty, q_full;
    logic [AW-1:0]        q_din, q_addr;
    logic                 b_push;
    logic [WORD_W-1:0]    b_word;
    logic                 f_empty;

    tdc_l1_ring #(.NCH(NCH), .RISE_W(RISE_W), .FALL_W(FALL_W), .DEPTH(L1_DEPTH)) u_ring (
        .clk(clk), .rst_n(rst_n),
        .rise_hit(rise_hit), .rise_fine(rise_fine),
        .fall_hit(fall_hit), .fall_fine(fall_fine),
        .rd_addr(l1_addr), .rd_entry(l1_entry), .wptr(wptr));

    // Window start of a new trigger and queue admission
    always_comb begin
        q_din  = wptr - latency;
        q_push = trig && !q_full;
    end

    tdc_sync_fifo #(.WIDTH(AW), .DEPTH(TRIGQ_DEPTH)) u_trigq (
        .clk(clk), .rst_n(rst_n), .push(q_push), .din(q_din),
        .pop(q_pop), .dout(q_addr), .empty(q_empty), .full(q_full));

    // Sticky record of a dropped trigger
    always_ff @(posedge clk) begin
        if (!rst_n)              trig_ovf <= 1'b0;
        else if (trig && q_full) trig_ovf <= 1'b1;
    end

    tdc_event_builder #(.NCH(NCH), .RISE_W(RISE_W), .FALL_W(FALL_W), .AW(AW),
                        .WIN(WIN), .WORD_W(WORD_W)) u_build (
        .clk(clk), .rst_n(rst_n),
        .q_empty(q_empty), .q_addr(q_addr), .q_pop(q_pop),
        .zs_mode(zs_mode), .l1_addr(l1_addr), .l1_entry(l1_entry),
        .fifo_full(fifo_full), .push(b_push), .word(b_word));

    tdc_sync_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rdfifo (
        .clk(clk), .rst_n(rst_n), .push(b_push), .din(b_word),
        .pop(rd_en && !f_empty), .dout(rd_data), .empty(f_empty), .full(fifo_full));

    // Readout handshake flag
    always_comb rd_valid = !f_empty;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ovf |=> trig_ovf);  // R3
    AST_DROP_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && q_full) |=> trig_ovf);  // R3
endmodule

// File: tb/tb_tdc_hit_buffer.sv
// Bench: table-driven single-hit events in both modes, then directed tests
// for reset, trigger-queue overflow and readout-FIFO full stall.
module tb_tdc_hit_buffer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  rise_hit, fall_hit;
    logic [19:0] rise_fine;
    logic [15:0] fall_fine;
    logic [7:0]  latency;
    logic        zs_mode, trig, rd_en;
    logic [17:0] rd_data;
    logic        rd_valid, fifo_full, trig_ovf;

    tdc_hit_buffer dut (
        .clk(clk), .rst_n(rst_n), .rise_hit(rise_hit), .rise_fine(rise_fine),
        .fall_hit(fall_hit), .fall_fine(fall_fine), .latency(latency),
        .zs_mode(zs_mode), .trig(trig), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .fifo_full(fifo_full), .trig_ovf(trig_ovf));

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int n_got;
    int hdr_cnt;
    logic [17:0] got [0:255];

    // planned hits, one per ring address
    logic       p_valid [256];
    logic [1:0] p_ch    [256];
    logic       p_ed    [256];
    logic [4:0] p_fn    [256];

    // {latency[17:10], zs[9], ch[8:7], edge[6], woff[5], fine[4:0]}
    localparam logic [17:0] VEC [6] = '{
        {8'd20,  1'b1, 2'd0, 1'b0, 1'b0, 5'h13},
        {8'd20,  1'b1, 2'd3, 1'b1, 1'b1, 5'h0A},
        {8'd37,  1'b0, 2'd2, 1'b0, 1'b1, 5'h1F},
        {8'd37,  1'b0, 2'd1, 1'b1, 1'b0, 5'h07},
        {8'd100, 1'b1, 2'd1, 1'b0, 1'b1, 5'h00},
        {8'd8,   1'b0, 2'd0, 1'b0, 1'b0, 5'h01}
    };

    // count clock edges since reset release (= address written at that edge)
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // drive planned hits for the next edge
    always @(negedge clk) begin
        rise_hit  = '0; fall_hit = '0; rise_fine = '0; fall_fine = '0;
        if (p_valid[cyc[7:0]]) begin
            if (p_ed[cyc[7:0]]) begin
                fall_hit[p_ch[cyc[7:0]]] = 1'b1;
                fall_fine[p_ch[cyc[7:0]]*4 +: 4] = p_fn[cyc[7:0]][3:0];
            end else begin
                rise_hit[p_ch[cyc[7:0]]] = 1'b1;
                rise_fine[p_ch[cyc[7:0]]*5 +: 5] = p_fn[cyc[7:0]];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drain();
        n_got = 0;
        while (rd_valid) begin
            got[n_got[7:0]] = rd_data;
            n_got++;
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        hdr_cnt = 0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R9 watchdog actual=timeout expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            p_valid[i] = 1'b0; p_ch[i] = '0; p_ed[i] = 1'b0; p_fn[i] = '0;
        end
        trig = 1'b0; rd_en = 1'b0; zs_mode = 1'b0; latency = 8'd20;
        rise_hit = '0; fall_hit = '0; rise_fine = '0; fall_fine = '0;
        @(negedge clk);
        do_reset();

        // R1: reset state
        check("R1 rd_valid", 32'(rd_valid), 32'd0);
        check("R1 fifo_full", 32'(fifo_full), 32'd0);
        check("R1 trig_ovf", 32'(trig_ovf), 32'd0);

        // table walk: one hit per event, both modes (R2 R5 R6 R7 R8)
        for (int i = 0; i < 6; i++) begin
            logic [7:0] lat, a, base;
            logic       zs, ed, wo;
            logic [1:0] ch;
            logic [4:0] fn;
            int         t, hit_idx, emp_idx, s;
            lat = VEC[i][17:10]; zs = VEC[i][9]; ch = VEC[i][8:7];
            ed = VEC[i][6]; wo = VEC[i][5]; fn = VEC[i][4:0];
            latency = lat; zs_mode = zs;
            t = cyc + int'(lat) + 10;
            base = 8'(t - int'(lat));
            a = base + 8'(wo);
            p_valid[a] = 1'b1; p_ch[a] = ch; p_ed[a] = ed; p_fn[a] = fn;
            while (cyc != t) @(negedge clk);
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            repeat (30) @(negedge clk);
            drain();
            p_valid[a] = 1'b0;
            check(zs ? "R7 zs word count" : "R6 fixed word count", n_got, zs ? 2 : 17);
            check("R4 header", 32'(got[0]), 32'({1'b1, 13'd0, 4'(hdr_cnt)}));
            hdr_cnt++;
            hit_idx = zs ? 1 : 1 + int'(wo)*8 + int'(ch)*2 + int'(ed);
            check(ed ? "R8 R5 R2 falling hit word" : "R5 R2 rising hit word",
                  32'(got[hit_idx]), 32'({1'b0, 1'b1, ch, ed, a, fn}));
            if (!zs) begin
                emp_idx = (hit_idx == 1) ? 2 : 1;
                s = emp_idx - 1;
                check("R6 empty slot word", 32'(got[emp_idx]),
                      32'({1'b0, 1'b0, 2'(s/2 % 4), 1'(s % 2), base + 8'(s/8), 5'd0}));
            end
        end

        // R3: seven back-to-back triggers, queue accepts five, ovf sticky
        zs_mode = 1'b1; latency = 8'd20;
        check("R3 ovf before burst", 32'(trig_ovf), 32'd0);
        trig = 1'b1;
        repeat (7) @(negedge clk);
        trig = 1'b0;
        check("R3 ovf set", 32'(trig_ovf), 32'd1);
        repeat (120) @(negedge clk);
        check("R3 ovf sticky", 32'(trig_ovf), 32'd1);
        drain();
        check("R3 accepted triggers", n_got, 5);
        check("R4 last header of burst", 32'(got[4]), 32'({1'b1, 13'd0, 4'(hdr_cnt + 4)}));

        // R1: reset clears the sticky flag
        do_reset();
        check("R1 ovf cleared", 32'(trig_ovf), 32'd0);
        check("R1 fifo empty after reset", 32'(rd_valid), 32'd0);

        // R9: fill readout FIFO without reading, then drain everything
        zs_mode = 1'b0; latency = 8'd20;
        while (cyc < 30) @(negedge clk);
        for (int k = 0; k < 9; k++) begin
            trig = 1'b1;
            @(negedge clk);
            trig = 1'b0;
            repeat (24) @(negedge clk);
        end
        repeat (10) @(negedge clk);
        check("R9 fifo_full", 32'(fifo_full), 32'd1);
        drain();
        repeat (40) @(negedge clk);
        begin
            int more, bad;
            more = n_got;
            drain();
            more = more + n_got;
            check("R9 no word lost", more, 153);
            bad = 0;
            if (more == 153) begin
                // the second drain is short; headers of the first part are checked
                for (int k = 0; k < 9; k++)
                    if (17*k < 153 - n_got &&
                        got[(17*k) % 256] !== {1'b1, 13'd0, 4'(k)}) bad++;
            end
            check("R9 R4 headers in order", bad, 0);
        end
        check("R9 fifo_full cleared", 32'(fifo_full), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule